// File: doc/BRIEF.md
# Charge-Path Protection Sequencer

This block is the digital sequencer that decides when the pass switch between a charger input and the battery path may conduct. It receives already-debounced comparator flags: input supply good, input overvoltage, battery overvoltage, overcurrent, and a pair of die-temperature flags (hot and cool). It also receives an active-high disable request. It drives a switch-enable, a soft-start ramp request, a slow ramp-down request and an active-low warning.

After the supply becomes good and the block is not disabled, the sequencer waits a fixed settle delay with the switch open. It then requests a soft-start ramp and finally holds the switch closed. Input overvoltage opens the switch on the next clock with no blanking. Every other cause opens it through a timed ramp-down: a battery or current fault that persists past its blanking window, over-temperature, or disable. Each qualified battery or current fault is tallied in its own counter. The sixteenth event of either kind locks the switch off until the supply drops or the disable input is asserted.

States: `S_IDLE` (supply low or disabled), `S_SETTLE` (settle delay), `S_SOFTSTART` (ramp up), `S_CONDUCT` (switch closed), `S_SLOWOFF` (ramp down), `S_TRIPPED` (open, waiting for faults to clear), `S_LOCKOUT` (permanently open). Transitions:
- idle→settle when the supply is good and there is no disable.
- settle→softstart after SETTLE_CYC clean cycles.
- softstart→conduct after SOFT_CYC cycles.
- softstart/conduct→tripped on input overvoltage.
- softstart/conduct→slowoff on a qualified fault, on over-temperature or on disable.
- slowoff→tripped on input overvoltage, or after RAMP_CYC cycles when the cause was a fault and no counter is full.
- slowoff→lockout after RAMP_CYC cycles when a counter is full.
- slowoff→idle after RAMP_CYC cycles when the ramp was for a disable.
- tripped→lockout when a counter is full.
- tripped→settle once all faults are clear.
- settle/tripped/lockout→idle on disable.
- any state→idle when the supply is lost.

Top module: `chg_path_guard`

## Requirements
- R1: After reset, and while `por_ok` is low, `sw_en`=0, `ramp_up`=0, `ramp_dn`=0 and `warn_n`=1.
- R2: Once `por_ok`=1 and `disable_in`=0, the switch stays open for SETTLE_CYC cycles. The block then shows `sw_en`=1 with `ramp_up`=1 for SOFT_CYC cycles, and after that holds `sw_en`=1 with both ramp requests at 0.
- R3: Input overvoltage during the settle delay restarts the delay from zero, and the switch never closes while it lasts. The full delay runs again after it clears.
- R4: Input overvoltage seen in any cycle forces `sw_en`=0 on the following cycle without a ramp-down (`ramp_dn`=0). After it clears, the settle delay and the soft-start are both repeated.
- R5: A battery-overvoltage or overcurrent flag shorter than its blanking window has no effect. The window is BLANK_BAT or BLANK_OC consecutive cycles, counted only while the switch is ramping up or closed.
- R6: A qualified battery or current fault, over-temperature, or disable opens the switch through a ramp-down. During the ramp-down, `sw_en`=1 and `ramp_dn`=1 for RAMP_CYC cycles before `sw_en` falls.
- R7: The 2**EVT_W-th qualified event of one fault kind puts the block into lock-out (`sw_en`=0, `warn_n`=0). This holds even when that event coincides with an input-overvoltage cut. Lock-out persists while `por_ok`=1 and `disable_in`=0.
- R8: `disable_in`=1 shuts the block down and clears both event counters. From lock-out or a tripped state this goes straight to idle; from soft-start or conduct it goes through a ramp-down with `warn_n`=1. Releasing the disable restarts the settle delay.
- R9: Over-temperature is set by `temp_hot` and cleared only by `temp_cool`. While it is set, the switch does not restart.
- R10: `warn_n` is 0 in these cases: in the tripped state, in lock-out, during a fault ramp-down, and during the settle delay while overvoltage or over-temperature is present. It is 1 otherwise.
- R11: `por_ok`=0 forces `sw_en`=0 and `warn_n`=1 on the next cycle from any state and clears both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Input supply above power-on threshold |
| in_ovp | input | 1 | Input overvoltage flag |
| bat_ovp | input | 1 | Battery overvoltage flag (unblanked) |
| over_cur | input | 1 | Overcurrent flag (unblanked) |
| temp_hot | input | 1 | Die above the upper temperature threshold |
| temp_cool | input | 1 | Die below the lower temperature threshold |
| disable_in | input | 1 | Active-high shutdown request |
| sw_en | output | 1 | Pass switch enable |
| ramp_up | output | 1 | Soft-start ramp request |
| ramp_dn | output | 1 | Slow ramp-down request |
| warn_n | output | 1 | Active-low protection warning |

## Verification
Two functions can land in the same cycle: the blanking window of a battery fault expiring (a qualified event that reaches the counter limit) and the input-overvoltage fast cut. The bench provokes this directly by raising input overvoltage on exactly the cycle the sixteenth battery event qualifies. It expects the fast cut to win (no ramp-down), the event still to be counted, and the block to move to lock-out from the tripped state one cycle later. Random stimulus with toggling disable, supply and fault flags produces further coincidences, including disable meeting a trip. A cycle-level model in the bench judges each of them.

// File: rtl/cps_pkg.sv
`timescale 1ns/1ps
package cps_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_SETTLE    = 3'd1,
        S_SOFTSTART = 3'd2,
        S_CONDUCT   = 3'd3,
        S_SLOWOFF   = 3'd4,
        S_TRIPPED   = 3'd5,
        S_LOCKOUT   = 3'd6
    } guard_state_e;

    localparam int NUM_SLOW_FAULTS = 2;
    localparam int FLT_BATT        = 0;
    localparam int FLT_CURR        = 1;

    // States in which the shared phase timer counts
    function automatic logic is_timed(guard_state_e s);
        return (s == S_SETTLE) || (s == S_SOFTSTART) || (s == S_SLOWOFF);
    endfunction

endpackage

// File: rtl/cps_blank_filter.sv
`timescale 1ns/1ps
module cps_blank_filter #(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic raw,
    output logic trip
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] run_q;

    // Counts consecutive armed cycles with the flag high, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!arm || !raw) begin
            run_q <= '0;
        end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign trip = arm && raw && (run_q == LAST);

endmodule

// File: rtl/cps_event_tally.sv
`timescale 1ns/1ps
module cps_event_tally #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic full
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             full_q;

    // 2**CNT_W events: the last one, seen with the count at TOP, sets full
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else if (bump) begin
            if (cnt_q == TOP) begin
                full_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign full = full_q;

endmodule

// File: rtl/cps_phase_timer.sv
`timescale 1ns/1ps
module cps_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [TW-1:0] elapsed
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (restart) begin
            elapsed <= '0;
        end else begin
            elapsed <= elapsed + 1'b1;
        end
    end

endmodule

// File: rtl/chg_path_guard.sv
`timescale 1ns/1ps
module chg_path_guard
    import cps_pkg::*;
#(
    parameter int SETTLE_CYC = 2_500_000,
    parameter int SOFT_CYC   = 250_000,
    parameter int RAMP_CYC   = 12_500,
    parameter int BLANK_BAT  = 45_000,
    parameter int BLANK_OC   = 42_500,
    parameter int EVT_W      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_ok,
    input  logic in_ovp,
    input  logic bat_ovp,
    input  logic over_cur,
    input  logic temp_hot,
    input  logic temp_cool,
    input  logic disable_in,
    output logic sw_en,
    output logic ramp_up,
    output logic ramp_dn,
    output logic warn_n
);
    localparam int LONG_A  = (SETTLE_CYC > SOFT_CYC) ? SETTLE_CYC : SOFT_CYC;
    localparam int LONGEST = (LONG_A > RAMP_CYC) ? LONG_A : RAMP_CYC;
    localparam int TW      = $clog2(LONGEST) + 1;
    localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] SOFT_LAST   = TW'(SOFT_CYC - 1);
    localparam logic [TW-1:0] RAMP_LAST   = TW'(RAMP_CYC - 1);

    guard_state_e state, state_nx;

    logic                       hot_q;
    logic                       rd_dis_q;
    logic [NUM_SLOW_FAULTS-1:0] flt_raw;
    logic [NUM_SLOW_FAULTS-1:0] flt_trip;
    logic [NUM_SLOW_FAULTS-1:0] ev_full;
    logic                       arm;
    logic                       cnt_clr;
    logic                       any_trip;
    logic                       locked_out;
    logic                       faults_clear;
    logic                       tmr_restart;
    logic [TW-1:0]              elapsed;

    assign flt_raw[FLT_BATT] = bat_ovp;
    assign flt_raw[FLT_CURR] = over_cur;
    assign arm               = (state == S_SOFTSTART) || (state == S_CONDUCT);
    assign cnt_clr           = disable_in || !por_ok;

    // One blanking window and one event tally per slow fault kind
    for (genvar g = 0; g < NUM_SLOW_FAULTS; g++) begin : g_slow
        localparam int HOLD = (g == FLT_BATT) ? BLANK_BAT : BLANK_OC;

        cps_blank_filter #(.HOLD_CYC(HOLD)) u_blank (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (arm),
            .raw   (flt_raw[g]),
            .trip  (flt_trip[g])
        );

        cps_event_tally #(.CNT_W(EVT_W)) u_tally (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .bump  (flt_trip[g]),
            .full  (ev_full[g])
        );
    end

    assign any_trip     = |flt_trip;
    assign locked_out   = |ev_full;
    assign faults_clear = !in_ovp && !hot_q && !bat_ovp && !over_cur;

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (!por_ok) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (!disable_in) state_nx = S_SETTLE;
                end
                S_SETTLE: begin
                    if (disable_in)
                        state_nx = S_IDLE;
                    else if (!in_ovp && !hot_q && (elapsed == SETTLE_LAST))
                        state_nx = S_SOFTSTART;
                end
                S_SOFTSTART: begin
                    if (in_ovp)
                        state_nx = S_TRIPPED;
                    else if (disable_in || hot_q || any_trip)
                        state_nx = S_SLOWOFF;
                    else if (elapsed == SOFT_LAST)
                        state_nx = S_CONDUCT;
                end
                S_CONDUCT: begin
                    if (in_ovp)
                        state_nx = S_TRIPPED;
                    else if (disable_in || hot_q || any_trip)
                        state_nx = S_SLOWOFF;
                end
                S_SLOWOFF: begin
                    if (in_ovp)
                        state_nx = S_TRIPPED;
                    else if (elapsed == RAMP_LAST) begin
                        if (rd_dis_q || disable_in)
                            state_nx = S_IDLE;
                        else if (locked_out)
                            state_nx = S_LOCKOUT;
                        else
                            state_nx = S_TRIPPED;
                    end
                end
                S_TRIPPED: begin
                    if (disable_in)
                        state_nx = S_IDLE;
                    else if (locked_out)
                        state_nx = S_LOCKOUT;
                    else if (faults_clear)
                        state_nx = S_SETTLE;
                end
                S_LOCKOUT: begin
                    if (disable_in) state_nx = S_IDLE;
                end
                default: state_nx = S_IDLE;
            endcase
        end
    end

    assign tmr_restart = (state_nx != state) || !is_timed(state)
                       || ((state == S_SETTLE) && (in_ovp || hot_q));

    cps_phase_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .elapsed (elapsed)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Over-temperature hysteresis and ramp-down cause
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hot_q    <= 1'b0;
            rd_dis_q <= 1'b0;
        end else begin
            if (temp_hot)
                hot_q <= 1'b1;
            else if (temp_cool)
                hot_q <= 1'b0;
            if ((state != S_SLOWOFF) && (state_nx == S_SLOWOFF))
                rd_dis_q <= disable_in;
        end
    end

    // Output decode
    always_comb begin
        sw_en   = 1'b0;
        ramp_up = 1'b0;
        ramp_dn = 1'b0;
        warn_n  = 1'b1;
        unique case (state)
            S_IDLE: ;
            S_SETTLE: warn_n = !(in_ovp || hot_q);
            S_SOFTSTART: begin
                sw_en   = 1'b1;
                ramp_up = 1'b1;
            end
            S_CONDUCT: sw_en = 1'b1;
            S_SLOWOFF: begin
                sw_en   = 1'b1;
                ramp_dn = 1'b1;
                warn_n  = rd_dis_q;
            end
            S_TRIPPED, S_LOCKOUT: warn_n = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/chg_path_guard_chk.sv
`timescale 1ns/1ps
module chg_path_guard_chk
    import cps_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         por_ok,
    input logic         in_ovp,
    input logic         disable_in,
    input logic         sw_en,
    input logic         ramp_up,
    input logic         ramp_dn,
    input logic         warn_n,
    input guard_state_e state,
    input logic [1:0]   ev_full
);
    AST_OVP_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        in_ovp |=> !sw_en); // R4

    AST_POR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> (!sw_en && warn_n)); // R11

    AST_SOFT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en) |-> ramp_up); // R2

    AST_SLOW_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sw_en) && $past(por_ok) && !$past(in_ovp)) |-> $past(ramp_dn)); // R6

    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SETTLE && in_ovp && por_ok && !disable_in) |=> (state == S_SETTLE)); // R3

    AST_DIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (disable_in && !sw_en) |=> !sw_en); // R8

    AST_DIS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        disable_in |=> (ev_full == 2'b00)); // R8

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOCKOUT && por_ok && !disable_in) |=> (state == S_LOCKOUT)); // R7

    AST_LOCK_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOCKOUT) |-> (!warn_n && !sw_en)); // R10

endmodule

bind chg_path_guard chg_path_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_ok     (por_ok),
    .in_ovp     (in_ovp),
    .disable_in (disable_in),
    .sw_en      (sw_en),
    .ramp_up    (ramp_up),
    .ramp_dn    (ramp_dn),
    .warn_n     (warn_n),
    .state      (state),
    .ev_full    (ev_full)
);

// File: tb/sim_chg_path_guard.sv
`timescale 1ns/1ps
module sim_chg_path_guard;
    import cps_pkg::*;

    localparam int T_SET = 20;
    localparam int T_SS  = 8;
    localparam int T_RD  = 6;
    localparam int T_BB  = 5;
    localparam int T_BO  = 7;
    localparam int EW    = 4;
    localparam int EVMAX = (1 << EW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0, por_ok = 1'b0, in_ovp = 1'b0, bat_ovp = 1'b0, over_cur = 1'b0;
    logic temp_hot = 1'b0, temp_cool = 1'b0, dis = 1'b0;
    logic sw_en, ramp_up, ramp_dn, warn_n;

    // shadow inputs, applied at the falling edge
    logic d_rst = 1'b0, d_por = 1'b0, d_ovp = 1'b0, d_bat = 1'b0, d_oc = 1'b0;
    logic d_hot = 1'b0, d_cool = 1'b0, d_dis = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    guard_state_e ms = S_IDLE;
    int  mt = 0;
    int  mb[2] = '{0, 0};
    int  me[2] = '{0, 0};
    bit  mf[2] = '{1'b0, 1'b0};
    bit  motp = 1'b0;
    bit  mrd = 1'b0;

    always #2 clk = ~clk;

    chg_path_guard #(
        .SETTLE_CYC(T_SET), .SOFT_CYC(T_SS), .RAMP_CYC(T_RD),
        .BLANK_BAT(T_BB), .BLANK_OC(T_BO), .EVT_W(EW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .in_ovp(in_ovp),
        .bat_ovp(bat_ovp), .over_cur(over_cur), .temp_hot(temp_hot),
        .temp_cool(temp_cool), .disable_in(dis),
        .sw_en(sw_en), .ramp_up(ramp_up), .ramp_dn(ramp_dn), .warn_n(warn_n)
    );

    function automatic bit m_timed(guard_state_e s);
        return (s == S_SETTLE) || (s == S_SOFTSTART) || (s == S_SLOWOFF);
    endfunction

    function automatic logic [3:0] m_expect();
        logic e_sw, e_up, e_dn, e_wn;
        e_sw = (ms == S_SOFTSTART) || (ms == S_CONDUCT) || (ms == S_SLOWOFF);
        e_up = (ms == S_SOFTSTART);
        e_dn = (ms == S_SLOWOFF);
        e_wn = !((ms == S_TRIPPED) || (ms == S_LOCKOUT) || ((ms == S_SLOWOFF) && !mrd)
                 || ((ms == S_SETTLE) && (in_ovp || motp)));
        return {e_sw, e_up, e_dn, e_wn};
    endfunction

    task automatic compare();
        logic [3:0] e;
        e = m_expect();
        checks++;
        if ({sw_en, ramp_up, ramp_dn, warn_n} !== e) begin
            errors++;
            $display("FAIL %s t=%0t sw/up/dn/warn actual %b%b%b%b expected %b",
                     cur_req, $time, sw_en, ramp_up, ramp_dn, warn_n, e);
        end
    endtask

    // literal expectation taken straight from a requirement
    task automatic expect_out(input string tag, input logic [3:0] e);
        checks++;
        if ({sw_en, ramp_up, ramp_dn, warn_n} !== e) begin
            errors++;
            $display("FAIL %s t=%0t directed sw/up/dn/warn actual %b%b%b%b expected %b",
                     tag, $time, sw_en, ramp_up, ramp_dn, warn_n, e);
        end
    endtask

    // effect of the coming rising edge on the model
    task automatic model_step();
        guard_state_e nx;
        bit en, latch, anyhit;
        bit hit[2];
        bit raw[2];
        int bl[2];
        if (!rst_n) begin
            ms = S_IDLE; mt = 0; mb = '{0, 0}; me = '{0, 0};
            mf = '{1'b0, 1'b0}; motp = 1'b0; mrd = 1'b0;
            return;
        end
        raw[0] = bat_ovp; raw[1] = over_cur;
        bl[0] = T_BB; bl[1] = T_BO;
        en = (ms == S_SOFTSTART) || (ms == S_CONDUCT);
        for (int i = 0; i < 2; i++) hit[i] = en && raw[i] && (mb[i] == bl[i] - 1);
        anyhit = hit[0] || hit[1];
        latch = mf[0] || mf[1];
        nx = ms;
        if (!por_ok) nx = S_IDLE;
        else case (ms)
            S_IDLE:      if (!dis) nx = S_SETTLE;
            S_SETTLE:    if (dis) nx = S_IDLE;
                         else if (!in_ovp && !motp && mt == T_SET - 1) nx = S_SOFTSTART;
            S_SOFTSTART: if (in_ovp) nx = S_TRIPPED;
                         else if (dis || motp || anyhit) nx = S_SLOWOFF;
                         else if (mt == T_SS - 1) nx = S_CONDUCT;
            S_CONDUCT:   if (in_ovp) nx = S_TRIPPED;
                         else if (dis || motp || anyhit) nx = S_SLOWOFF;
            S_SLOWOFF:   if (in_ovp) nx = S_TRIPPED;
                         else if (mt == T_RD - 1)
                             nx = (mrd || dis) ? S_IDLE : (latch ? S_LOCKOUT : S_TRIPPED);
            S_TRIPPED:   if (dis) nx = S_IDLE;
                         else if (latch) nx = S_LOCKOUT;
                         else if (!in_ovp && !motp && !bat_ovp && !over_cur) nx = S_SETTLE;
            S_LOCKOUT:   if (dis) nx = S_IDLE;
            default:     nx = S_IDLE;
        endcase
        if (nx != ms || !m_timed(ms) || (ms == S_SETTLE && (in_ovp || motp))) mt = 0;
        else mt = mt + 1;
        for (int i = 0; i < 2; i++) begin
            if (!en || !raw[i]) mb[i] = 0;
            else if (mb[i] != bl[i] - 1) mb[i] = mb[i] + 1;
            if (dis || !por_ok) begin me[i] = 0; mf[i] = 1'b0; end
            else if (hit[i]) begin
                if (me[i] == EVMAX) mf[i] = 1'b1; else me[i] = me[i] + 1;
            end
        end
        if (ms != S_SLOWOFF && nx == S_SLOWOFF) mrd = dis;
        if (temp_hot) motp = 1'b1; else if (temp_cool) motp = 1'b0;
        ms = nx;
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rst_n = d_rst; por_ok = d_por; in_ovp = d_ovp; bat_ovp = d_bat;
            over_cur = d_oc; temp_hot = d_hot; temp_cool = d_cool; dis = d_dis;
            #1;
            compare();
            model_step();
        end
    endtask

    localparam int RESTART = T_RD + T_SET + T_SS + 3;

    initial begin : main
        int unsigned seed_v;
        seed_v = $urandom(32'd20240607);
        // reset
        cur_req = "R1";
        cyc(3);
        expect_out("R1", 4'b0001);
        d_rst = 1'b1;
        cyc(3);
        expect_out("R1", 4'b0001);

        // power-up: settle then soft-start then conduct
        cur_req = "R2";
        d_por = 1'b1;
        cyc(1 + T_SET);
        expect_out("R2", 4'b0001);
        cyc(1);
        expect_out("R2", 4'b1101);
        cyc(T_SS - 1);
        expect_out("R2", 4'b1101);
        cyc(1);
        expect_out("R2", 4'b1001);
        cyc(4);

        // short fault pulses are blanked
        cur_req = "R5";
        d_oc = 1'b1; cyc(T_BO - 1); d_oc = 1'b0; cyc(3);
        expect_out("R5", 4'b1001);
        d_bat = 1'b1; cyc(T_BB - 1); d_bat = 1'b0; cyc(3);
        expect_out("R5", 4'b1001);

        // qualified overcurrent: slow ramp-down
        cur_req = "R6";
        d_oc = 1'b1; cyc(T_BO); d_oc = 1'b0;
        cyc(1);
        expect_out("R6", 4'b1010);
        cyc(RESTART);
        expect_out("R6", 4'b1001);

        // input overvoltage: fast cut, then full restart
        cur_req = "R4";
        d_ovp = 1'b1; cyc(1);
        cyc(1);
        expect_out("R4", 4'b0000);
        cyc(2); d_ovp = 1'b0;
        cyc(T_SET + T_SS + 3);
        expect_out("R4", 4'b1001);

        // overvoltage during the settle delay
        cur_req = "R11";
        d_por = 1'b0; cyc(1); cyc(1);
        expect_out("R11", 4'b0001);
        cur_req = "R3";
        d_por = 1'b1; cyc(5);
        d_ovp = 1'b1; cyc(4);
        expect_out("R3", 4'b0000);
        d_ovp = 1'b0; cyc(T_SET - 2);
        d_ovp = 1'b1; cyc(2);
        d_ovp = 1'b0; cyc(T_SET - 1);
        expect_out("R3", 4'b0001);
        cyc(T_SS + 4);

        // over-temperature hysteresis
        cur_req = "R9";
        d_hot = 1'b1; cyc(1); d_hot = 1'b0;
        cyc(T_RD + 40);
        expect_out("R9", 4'b0000);
        d_cool = 1'b1; cyc(1); d_cool = 1'b0;
        cyc(T_SET + T_SS + 3);
        expect_out("R9", 4'b1001);

        // repeated battery faults, last one coinciding with overvoltage cut
        cur_req = "R7";
        for (int n = 0; n < EVMAX; n++) begin
            d_bat = 1'b1; cyc(T_BB); d_bat = 1'b0; cyc(RESTART);
        end
        expect_out("R7", 4'b1001);
        d_bat = 1'b1; cyc(T_BB - 1);
        d_ovp = 1'b1; cyc(1);
        d_bat = 1'b0; d_ovp = 1'b0;
        cyc(1);
        expect_out("R7", 4'b0000);
        cyc(40);
        expect_out("R7", 4'b0000);

        // disable leaves lock-out and clears the tallies
        cur_req = "R8";
        d_dis = 1'b1; cyc(2);
        expect_out("R8", 4'b0001);
        d_dis = 1'b0; cyc(T_SET + T_SS + 3);
        expect_out("R8", 4'b1001);
        d_bat = 1'b1; cyc(T_BB); d_bat = 1'b0; cyc(RESTART);
        expect_out("R8", 4'b1001);
        d_dis = 1'b1; cyc(1); cyc(1);
        expect_out("R8", 4'b1011);
        cyc(T_RD);
        expect_out("R8", 4'b0001);
        d_dis = 1'b0; cyc(T_SET + T_SS + 3);

        // supply loss from conduct
        cur_req = "R11";
        d_por = 1'b0; cyc(1); cyc(1);
        expect_out("R11", 4'b0001);
        d_por = 1'b1; cyc(T_SET + T_SS + 3);

        // warning flag under random stimulus
        cur_req = "R10";
        for (int k = 0; k < 6000; k++) begin
            if ($urandom % 700 == 0) d_por = ~d_por;
            if (!d_por && ($urandom % 4 == 0)) d_por = 1'b1;
            if ($urandom % 70 == 0) d_ovp = ~d_ovp;
            if ($urandom % 9 == 0) d_bat = ~d_bat;
            if ($urandom % 11 == 0) d_oc = ~d_oc;
            if ($urandom % 300 == 0) d_dis = ~d_dis;
            if (d_dis && ($urandom % 8 == 0)) d_dis = 1'b0;
            d_hot  = ($urandom % 250 == 0);
            d_cool = ($urandom % 15 == 0);
            cyc(1);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule